// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Control Register

This block is the 8-bit control register that sits beside a real-time clock's counting logic. It holds a periodic interrupt flag, a 3-bit period select, a clock enable bit, a 30-second adjust request, a divider reset request and a count start bit. A CPU updates it through a single-cycle write port and reads it back combinationally. A small prescaler stub produces one-clock tick pulses at seven power-of-two periods. The period select picks one of them, and each selected tick sets the flag, which drives the periodic interrupt request.

Two reset inputs act on different bits. The power-on reset, like a synchronous deep-standby entry, loads the whole register. The manual reset clears everything except the clock enable and count start bits. The flag follows a two-state machine with the states FLAG_CLEAR and FLAG_SET. The transition SET_ON_EVENT goes from FLAG_CLEAR to FLAG_SET when a selected tick occurs or when software writes 1 to the flag. The transition CLEAR_BY_WRITE goes from FLAG_SET to FLAG_CLEAR when software writes 0 to the flag in a cycle with no tick. The transition CLEAR_BY_RESET goes from either state to FLAG_CLEAR on any reset. The adjust and divider reset bits act as one-cycle request pulses toward the counters.

Top module: `rtc_pctl_top`

## Requirements
- R1: Every bit is written from `wr_data` when `wr_en` is high and read on `rd_data`. The bit positions are: bit 7 flag, bits 6:4 period select, bit 3 clock enable, bit 2 adjust request, bit 1 divider reset request, bit 0 count start.
- R2: The register reads 8'h09 (clock enable and count start set, all else 0) with the prescale count at 0 in two cases: while `por_n` is low, which acts asynchronously, and after any clock edge at which `dstby` is high. `dstby` takes priority over `mrst_n`.
- R3: A clock edge with `mrst_n` low (and `dstby` low) clears bits 7:4, 2 and 1 and the prescale count. Bits 3 and 0 keep their values.
- R4: A 7-bit prescale count advances by one each clock while bit 0 is 1 and holds while bit 0 is 0. It is cleared at the edge that ends a cycle in which bit 1 reads 1. For a select value k from 1 to 7, a tick occurs in a cycle where bit 0 is 1 and the low k bits of the count are all ones. A select value of 0 produces no ticks.
- R5: A tick of the selected period sets the flag at the next clock edge.
- R6: A write with bit 7 at 1 sets the flag. A write with bit 7 at 0 clears it.
- R7: When a tick and a write of 0 to the flag fall in the same cycle, the flag ends up 1.
- R8: `pirq` equals the flag bit at all times.
- R9: The adjust and divider reset bits read 1 only in the cycle after a write of 1 and then clear themselves. `adj_req` and `div_rst_req` mirror them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| dstby | input | 1 | Deep-standby entry, synchronous register initialize |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| pirq | output | 1 | Periodic interrupt request |
| adj_req | output | 1 | 30-second adjust request pulse |
| div_rst_req | output | 1 | Divider reset request pulse |

## Verification
The assertions take for granted that `mrst_n`, `dstby`, `wr_en` and `wr_data` change only between clock edges. They also assume that `por_n` is the only asynchronous input, so any output sampled one edge after an input is attributable to that input. The stimulus drives every input on the falling clock edge. It releases `por_n` there too, away from the rising edge, and keeps the count start bit set in most random writes so that ticks at every period actually occur.

// File: rtl/rtc_pctl_pkg.sv
package rtc_pctl_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int NUM_SEL  = (1 << SEL_W) - 1;

    localparam int BIT_FLAG  = 7;
    localparam int BIT_SEL_L = 4;
    localparam int BIT_EN    = 3;
    localparam int BIT_ADJ   = 2;
    localparam int BIT_DIV   = 1;
    localparam int BIT_START = 0;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/rtc_prescaler_stub.sv
module rtc_prescaler_stub #(
    parameter int NUM_TAPS = 7,
    parameter int TAP_STEP = 1
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                clr,
    input  logic                run,
    output logic [NUM_TAPS-1:0] tick_vec
);
    localparam int CNT_W = NUM_TAPS * TAP_STEP;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign tick_vec[k] = run & (&cnt_q[(k+1)*TAP_STEP-1:0]);
    end
endmodule

// File: rtl/rtc_tick_select.sv
module rtc_tick_select #(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [(1<<SEL_W)-2:0]     tick_vec,
    output logic                      tick
);
    localparam int NUM_SEL = (1 << SEL_W) - 1;

    always_comb begin
        tick = 1'b0;
        for (int k = 1; k <= NUM_SEL; k++) begin
            if (sel == SEL_W'(k)) tick = tick_vec[k-1];
        end
    end
endmodule

// File: rtl/rtc_flag_fsm.sv
module rtc_flag_fsm
    import rtc_pctl_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sync_clr,
    input  logic tick,
    input  logic wr_en,
    input  logic wr_flag,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        state_q <= FLAG_CLEAR;
        else if (sync_clr) state_q <= FLAG_CLEAR;
        else               state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (tick || (wr_en && wr_flag))  state_d = FLAG_SET;
            FLAG_SET:   if (!tick && wr_en && !wr_flag)  state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/rtc_pctl_top.sv
module rtc_pctl_top
    import rtc_pctl_pkg::*;
#(
    parameter int TAP_STEP = 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             dstby,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pirq,
    output logic             adj_req,
    output logic             div_rst_req
);
    logic [SEL_W-1:0]   sel_q;
    logic               en_q, adj_q, div_q, start_q;
    logic               flag;
    logic               tick;
    logic               sync_clr;
    logic [NUM_SEL-1:0] tick_vec;

    assign sync_clr = dstby | ~mrst_n;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q   <= '0;
            en_q    <= 1'b1;
            adj_q   <= 1'b0;
            div_q   <= 1'b0;
            start_q <= 1'b1;
        end else if (dstby) begin
            sel_q   <= '0;
            en_q    <= 1'b1;
            adj_q   <= 1'b0;
            div_q   <= 1'b0;
            start_q <= 1'b1;
        end else if (!mrst_n) begin
            sel_q   <= '0;
            adj_q   <= 1'b0;
            div_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                sel_q   <= wr_data[BIT_SEL_L +: SEL_W];
                en_q    <= wr_data[BIT_EN];
                start_q <= wr_data[BIT_START];
            end
            adj_q <= wr_en & wr_data[BIT_ADJ];
            div_q <= wr_en & wr_data[BIT_DIV];
        end
    end

    rtc_prescaler_stub #(
        .NUM_TAPS (NUM_SEL),
        .TAP_STEP (TAP_STEP)
    ) u_presc (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (sync_clr | div_q),
        .run      (start_q),
        .tick_vec (tick_vec)
    );

    rtc_tick_select #(
        .SEL_W (SEL_W)
    ) u_sel (
        .sel      (sel_q),
        .tick_vec (tick_vec),
        .tick     (tick)
    );

    rtc_flag_fsm u_flag (
        .clk      (clk),
        .por_n    (por_n),
        .sync_clr (sync_clr),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_flag  (wr_data[BIT_FLAG]),
        .flag     (flag)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_FLAG]    = flag;
        rd_data[BIT_SEL_L +: SEL_W] = sel_q;
        rd_data[BIT_EN]      = en_q;
        rd_data[BIT_ADJ]     = adj_q;
        rd_data[BIT_DIV]     = div_q;
        rd_data[BIT_START]   = start_q;
    end

    assign pirq        = flag;
    assign adj_req     = adj_q;
    assign div_rst_req = div_q;
endmodule

// File: rtl/rtc_pctl_chk.sv
module rtc_pctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mrst_n,
    input logic       dstby,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pirq,
    input logic       adj_req,
    input logic       div_rst_req
);
    AST_PIRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        pirq == rd_data[7]); // R8

    AST_DSTBY_INIT: assert property (@(posedge clk) disable iff (!por_n)
        dstby |=> (rd_data == 8'h09)); // R2

    AST_MRST_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !dstby) |=> (rd_data[3] == $past(rd_data[3]) && rd_data[0] == $past(rd_data[0])
                                 && rd_data[7:4] == 4'b0 && rd_data[2:1] == 2'b0)); // R3

    AST_WR_SET_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_data[7] && mrst_n && !dstby) |=> rd_data[7]); // R6

    AST_SEL_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[6:4] == 3'd0 && !rd_data[7] && !(wr_en && wr_data[7])) |=> !rd_data[7]); // R4

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_data[0] && !rd_data[7] && !(wr_en && wr_data[7])) |=> !rd_data[7]); // R4

    AST_ADJ_SELFCLR: assert property (@(posedge clk) disable iff (!por_n)
        (adj_req && !(wr_en && wr_data[2])) |=> !adj_req); // R9

    AST_DIV_SELFCLR: assert property (@(posedge clk) disable iff (!por_n)
        (div_rst_req && !(wr_en && wr_data[1])) |=> !div_rst_req); // R9
endmodule

bind rtc_pctl_top rtc_pctl_chk u_chk (.*);

// File: tb/tb_rtc_pctl_top.sv
`timescale 1ns/1ps
module tb_rtc_pctl_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst_n = 1'b1;
    logic       dstby = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pirq, adj_req, div_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_pctl_top dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .dstby(dstby),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pirq(pirq), .adj_req(adj_req), .div_rst_req(div_rst_req)
    );

    // Reference model built from the requirements
    logic [7:0] m_reg;
    logic [6:0] m_cnt;

    function automatic logic model_tick(input logic [7:0] r, input logic [6:0] c);
        logic [2:0] s;
        logic [6:0] mask;
        s = r[6:4];
        mask = 7'((8'd1 << s) - 8'd1);
        return (s != 3'd0) && r[0] && ((c & mask) == mask);
    endfunction

    function automatic logic [7:0] model_next(input logic [7:0] r, input logic tk,
                                             input logic we, input logic [7:0] d);
        logic [7:0] n;
        n = r;
        if (we) begin
            n[6:4] = d[6:4];
            n[3]   = d[3];
            n[0]   = d[0];
        end
        n[2] = we & d[2];
        n[1] = we & d[1];
        n[7] = tk | (we ? d[7] : r[7]);
        return n;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_reg <= 8'h09;
            m_cnt <= '0;
        end else if (dstby) begin
            m_reg <= 8'h09;
            m_cnt <= '0;
        end else if (!mrst_n) begin
            m_reg <= m_reg & 8'b0000_1001;
            m_cnt <= '0;
        end else begin
            m_reg <= model_next(m_reg, model_tick(m_reg, m_cnt), wr_en, wr_data);
            if (m_reg[1])      m_cnt <= '0;
            else if (m_reg[0]) m_cnt <= m_cnt + 7'd1;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, rd_data, m_reg);
        check("R8", {7'd0, pirq}, {7'd0, m_reg[7]});
        check("R9", {6'd0, adj_req, div_rst_req}, {6'd0, m_reg[2], m_reg[1]});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        check("R2", rd_data, 8'h09);
        check("R8", {7'd0, pirq}, 8'd0);
        por_n = 1'b1;
        step();
        check_all("R2");

        // R1: write and read back
        write(8'h50);
        check("R1", rd_data, 8'h50);
        check_all("R1");

        // R4: start bit 0 holds prescaler, no ticks
        write(8'h18);
        for (int i = 0; i < 20; i++) step();
        check("R4", {7'd0, rd_data[7]}, 8'd0);
        // R4: select 0 gives no ticks while counting
        write(8'h09);
        for (int i = 0; i < 20; i++) step();
        check("R4", {7'd0, rd_data[7]}, 8'd0);
        check_all("R4");

        // R5: a selected tick sets the flag
        write(8'h39);
        for (int i = 0; i < 20 && !model_tick(m_reg, m_cnt); i++) step();
        step();
        check("R5", {7'd0, rd_data[7]}, 8'd1);
        check_all("R5");

        // R6: writes clear and set the flag
        write(8'h09);
        check("R6", {7'd0, rd_data[7]}, 8'd0);
        write(8'h89);
        check("R6", {7'd0, rd_data[7]}, 8'd1);
        check_all("R6");

        // R7: tick collides with a write of 0
        write(8'h19);
        for (int i = 0; i < 20 && !model_tick(m_reg, m_cnt); i++) step();
        write(8'h19);
        check("R7", {7'd0, rd_data[7]}, 8'd1);
        check_all("R7");

        // R9: request bits self-clear
        write(8'h0F);
        check("R9", {6'd0, adj_req, div_rst_req}, 8'd3);
        step();
        check("R9", {6'd0, adj_req, div_rst_req}, 8'd0);
        check_all("R9");

        // R3: manual reset keeps enable and start
        write(8'hF8);
        mrst_n = 1'b0;
        step();
        mrst_n = 1'b1;
        check("R3", rd_data, 8'h08);
        write(8'hF1);
        mrst_n = 1'b0;
        step();
        mrst_n = 1'b1;
        check("R3", rd_data, 8'h01);
        check_all("R3");

        // R2: deep standby initializes, wins over manual reset
        write(8'hF6);
        dstby = 1'b1;
        mrst_n = 1'b0;
        step();
        dstby = 1'b0;
        mrst_n = 1'b1;
        check("R2", rd_data, 8'h09);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 999);
            wr_en = ($urandom_range(0, 9) < 3);
            wr_data = 8'($urandom);
            if ($urandom_range(0, 9) < 8) wr_data[0] = 1'b1;
            mrst_n = (r >= 20);
            dstby = (r < 8);
            if (r >= 995) begin
                por_n = 1'b0;
                @(negedge clk);
                check("R2", rd_data, 8'h09);
                por_n = 1'b1;
            end
            step();
            check_all("R1");
        end
        wr_en = 1'b0;
        mrst_n = 1'b1;
        dstby = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule